// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences one conversion of a successive-approximation converter. A start pulse opens an acquisition window: the sample switch output stays high for a programmable number of clocks so that the external hold capacitor can settle. The block then loads an initial trial code and resolves the result one bit per clock, most significant bit first. In each bit cycle it drives a trial code to the external DAC and reads back one comparator decision. In the last cycle it presents the final code together with a one-clock done pulse.

The sample-and-hold stage, the DAC and the comparator are outside the block. A conversion lasts the acquisition clocks plus one clock per resolved bit plus two overhead clocks: one clock loads the first trial code and one clock latches the result. The full resolution is 12 bits. A reduced 10-bit mode can be selected per conversion. In that mode the two lowest result bits are zero and the conversion ends two clocks earlier. A start pulse that arrives while a conversion runs is dropped and reported to the sequencer that issued it.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no start, busy, done, sample_sw and start_ignored are 0, and dac_code and result are all zeros.
- R2: A start sampled while idle raises sample_sw in the next clock and holds it for exactly acq_len clocks. An acq_len of 0 acts as 1.
- R3: busy is high from the clock after an accepted start for acq_len + N + 2 clocks, where N is 12 in full mode and 10 in reduced mode. done is high for exactly one clock, and that clock is the last clock of busy.
- R4: The clock after sample_sw falls is a load clock. The N clocks after it are bit clocks, with k = 0 for the first. In bit clock k, dac_code equals the already decided bits above bit position 11-k, with bit 11-k set to 1 and all lower bits 0.
- R5: cmp_hi = 1 means the DAC output is above the held input, and it clears the bit under trial. cmp_hi = 0 keeps that bit. In full mode, with a comparator that reports dac_code > V, result equals V at the done clock.
- R6: With sub_res = 1 at the start, only bits 11 down to 2 are resolved. Result bits 1:0 are 0, so result equals V with its two low bits cleared, and the conversion is two clocks shorter.
- R7: A start sampled while busy is high (the done clock included) does not change the running conversion. start_ignored is high in the clock that follows it.
- R8: sub_res and acq_len are taken only at the accepted start. Changing them during a conversion does not change its length or its result.
- R9: result changes only in a clock in which done is high, and it holds its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, sampled each clock |
| sub_res | input | 1 | 1 selects the reduced 10-bit resolution |
| acq_len | input | ACQ_W | Acquisition length in clocks (0 acts as 1) |
| cmp_hi | input | 1 | Comparator: 1 when DAC output is above the held input |
| sample_sw | output | 1 | Closes the sample switch during acquisition |
| dac_code | output | RES_W | Trial code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-clock pulse when result is valid |
| result | output | RES_W | Final code, held until the next done |
| start_ignored | output | 1 | Pulse after a start that arrived while busy |

## Verification
The comparator model holds an input code and answers dac_code > V. The bench sweeps V across the 12-bit range in fixed steps, and also uses 0, 4095 and the codes on either side of the major bit boundaries. Each V runs in both resolution modes, so truncation and bit-clearing faults in the low bits show up only in the mode they affect. Acquisition lengths rotate through 0 to 5, plus a longer value, which separates off-by-one faults in the acquisition counter from faults in the frame length. In some conversions the start, sub_res and acq_len inputs are changed mid-conversion; a design that accepts a second start or re-reads its settings then produces a wrong length or a wrong code.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ACQ  = 3'd1,
      ST_LOAD = 3'd2,
      ST_BIT  = 3'd3,
      ST_DONE = 3'd4
   } sar_state_e;

endpackage

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
   parameter int ACQ_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ACQ_W-1:0] len,
   output logic             acq_last
);

   localparam logic [ACQ_W-1:0] ONE  = ACQ_W'(1);
   localparam logic [ACQ_W-1:0] ZERO = '0;

   logic [ACQ_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= ZERO;
      end else if (load) begin
         cnt_q <= (len == ZERO) ? ONE : len;
      end else if (cnt_q != ZERO) begin
         cnt_q <= cnt_q - ONE;
      end
   end

   assign acq_last = (cnt_q == ONE);

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
   parameter int RES_W  = 12,
   parameter int SUB_W  = 10,
   parameter bit SUB_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             step,
   input  logic             cmp_hi,
   input  logic             sub_mode,
   output logic [RES_W-1:0] trial,
   output logic [RES_W-1:0] result,
   output logic             bit_last
);

   localparam int LOW_W = RES_W - SUB_W;
   localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

   logic [RES_W-1:0] trial_q;
   logic [RES_W-1:0] mask_q;
   logic [RES_W-1:0] res_q;
   logic [RES_W-1:0] decided;

   // Drop the bit under trial when the DAC overshoots the held input.
   assign decided = cmp_hi ? (trial_q & ~mask_q) : trial_q;

   generate
      if (SUB_EN) begin : g_sub_stop
         assign bit_last = sub_mode ? mask_q[LOW_W] : mask_q[0];
      end else begin : g_full_stop
         logic unused_mode;
         assign unused_mode = sub_mode;
         assign bit_last    = mask_q[0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trial_q <= '0;
         mask_q  <= '0;
         res_q   <= '0;
      end else if (init) begin
         trial_q <= MSB_ONE;
         mask_q  <= MSB_ONE;
      end else if (step) begin
         if (bit_last) begin
            trial_q <= decided;
            mask_q  <= '0;
            res_q   <= decided;
         end else begin
            trial_q <= decided | (mask_q >> 1);
            mask_q  <= mask_q >> 1;
         end
      end
   end

   assign trial  = trial_q;
   assign result = res_q;

endmodule

// File: rtl/sar_frame_fsm.sv
module sar_frame_fsm
   import sar_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       acq_last,
   input  logic       bit_last,
   output sar_state_e state,
   output logic       accept,
   output logic       ignored
);

   sar_state_e state_q;
   sar_state_e state_d;
   logic       ign_q;

   assign accept = start && (state_q == ST_IDLE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start)    state_d = ST_ACQ;
         ST_ACQ:  if (acq_last) state_d = ST_LOAD;
         ST_LOAD:               state_d = ST_BIT;
         ST_BIT:  if (bit_last) state_d = ST_DONE;
         ST_DONE:               state_d = ST_IDLE;
         default:               state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ign_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         ign_q   <= start && (state_q != ST_IDLE);
      end
   end

   assign state   = state_q;
   assign ignored = ign_q;

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sar_seq_pkg::*;
#(
   parameter int RES_W  = 12,
   parameter int SUB_W  = 10,
   parameter bit SUB_EN = 1'b1,
   parameter int ACQ_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             sub_res,
   input  logic [ACQ_W-1:0] acq_len,
   input  logic             cmp_hi,
   output logic             sample_sw,
   output logic [RES_W-1:0] dac_code,
   output logic             busy,
   output logic             done,
   output logic [RES_W-1:0] result,
   output logic             start_ignored
);

   generate
      if (RES_W < 2) begin : g_bad_res
         $error("sar_seq_ctrl: RES_W must be at least 2");
      end
      if (SUB_W < 1 || SUB_W >= RES_W) begin : g_bad_sub
         $error("sar_seq_ctrl: SUB_W must lie in 1..RES_W-1");
      end
      if (ACQ_W < 2) begin : g_bad_acq
         $error("sar_seq_ctrl: ACQ_W must be at least 2");
      end
   endgenerate

   sar_state_e state;
   logic       accept;
   logic       acq_last;
   logic       bit_last;
   logic       mode_d;
   logic       mode_q;

   generate
      if (SUB_EN) begin : g_mode_sel
         assign mode_d = sub_res;
      end else begin : g_mode_fixed
         logic unused_sub;
         assign unused_sub = sub_res;
         assign mode_d     = 1'b0;
      end
   endgenerate

   // Resolution is frozen for the whole frame at the accepted start.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
      end else if (accept) begin
         mode_q <= mode_d;
      end
   end

   sar_frame_fsm i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .acq_last (acq_last),
      .bit_last (bit_last),
      .state    (state),
      .accept   (accept),
      .ignored  (start_ignored)
   );

   sar_acq_timer #(.ACQ_W(ACQ_W)) i_acq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .len      (acq_len),
      .acq_last (acq_last)
   );

   sar_bit_engine #(.RES_W(RES_W), .SUB_W(SUB_W), .SUB_EN(SUB_EN)) i_bits (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (state == ST_LOAD),
      .step     (state == ST_BIT),
      .cmp_hi   (cmp_hi),
      .sub_mode (mode_q),
      .trial    (dac_code),
      .result   (result),
      .bit_last (bit_last)
   );

   assign busy      = (state != ST_IDLE);
   assign sample_sw = (state == ST_ACQ);
   assign done      = (state == ST_DONE);

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int RES_W = 12,
   parameter int SUB_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             sample_sw,
   input logic [RES_W-1:0] result,
   input logic             start_ignored,
   input logic             mode_q
);

   localparam int LOW_W = RES_W - SUB_W;

   // R3
   done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R3
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));

   // R2
   sample_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_sw |-> busy);

   // R7
   ignored_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> start_ignored);

   // R9
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);

   // R6
   sub_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_q) |-> (result[LOW_W-1:0] == '0));

endmodule

bind sar_seq_ctrl sar_seq_chk #(.RES_W(RES_W), .SUB_W(SUB_W)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .busy          (busy),
   .done          (done),
   .sample_sw     (sample_sw),
   .result        (result),
   .start_ignored (start_ignored),
   .mode_q        (mode_q)
);

// File: tb/test_sar_seq_ctrl.sv
`timescale 1ns/1ps
module test_sar_seq_ctrl;

   localparam int RES_W = 12;
   localparam int ACQ_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             sub_res = 1'b0;
   logic [ACQ_W-1:0] acq_len = '0;
   logic             cmp_hi;
   logic             sample_sw;
   logic [RES_W-1:0] dac_code;
   logic             busy;
   logic             done;
   logic [RES_W-1:0] result;
   logic             start_ignored;
   logic [RES_W-1:0] vin_r = '0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   // Comparator model: high when the DAC output exceeds the held input.
   assign cmp_hi = (dac_code > vin_r);

   sar_seq_ctrl i_sar_seq_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .sub_res       (sub_res),
      .acq_len       (acq_len),
      .cmp_hi        (cmp_hi),
      .sample_sw     (sample_sw),
      .dac_code      (dac_code),
      .busy          (busy),
      .done          (done),
      .result        (result),
      .start_ignored (start_ignored)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic convert(input int vin, input bit sub, input int len, input bit disturb);
      int le, n, busy_cnt, samp_cnt, done_cnt, trial_bad, done_at, res_at, ign_seen;
      le = (len == 0) ? 1 : len;
      n  = sub ? 10 : 12;
      busy_cnt = 0; samp_cnt = 0; done_cnt = 0; trial_bad = 0;
      done_at = -1; res_at = -1; ign_seen = 0;
      @(negedge clk);
      vin_r = RES_W'(vin); sub_res = sub; acq_len = ACQ_W'(len); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 1; i <= 300; i++) begin
         if (!busy) break;
         busy_cnt++;
         if (sample_sw) samp_cnt++;
         if (sample_sw != (i <= le)) trial_bad++;
         if (i >= le + 2 && i <= le + 1 + n) begin
            int pos, expc;
            pos  = 11 - (i - le - 2);
            expc = ((vin >> (pos + 1)) << (pos + 1)) | (1 << pos);
            if (int'(dac_code) != expc) trial_bad++;
         end
         if (done) begin done_cnt++; done_at = i; res_at = int'(result); end
         if (disturb && i == 4) begin
            start = 1'b0; ign_seen = start_ignored;
            sub_res = sub; acq_len = ACQ_W'(len);
         end
         if (disturb && i == 3) begin
            start = 1'b1; sub_res = ~sub; acq_len = ACQ_W'(len + 5);
         end
         @(negedge clk);
      end
      // R2 acquisition window length and position
      check(samp_cnt == le, "R2 sample_sw clocks", samp_cnt, le);
      // R3 frame length and done placement
      check(busy_cnt == le + n + 2, sub ? "R3/R6 busy clocks" : "R3 busy clocks", busy_cnt, le + n + 2);
      check(done_cnt == 1 && done_at == le + n + 2, "R3 done position", done_at, le + n + 2);
      // R4 trial code sequence
      check(trial_bad == 0, "R4 trial sequence mismatches", trial_bad, 0);
      // R5 / R6 final code
      if (sub) check(res_at == (vin & ~3), "R6 reduced result", res_at, vin & ~3);
      else     check(res_at == vin, "R5 full result", res_at, vin);
      if (disturb) begin
         // R7 / R8 dropped start and frozen settings
         check(ign_seen == 1, "R7 start_ignored pulse", ign_seen, 1);
         check(busy_cnt == le + n + 2, "R8 settings frozen", busy_cnt, le + n + 2);
      end
      // R9 result held while idle
      @(negedge clk);
      check(int'(result) == res_at, "R9 result hold", int'(result), res_at);
   endtask

   initial begin
      #(4 * 190000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int len;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy == 0 && done == 0 && sample_sw == 0 && start_ignored == 0,
            "R1 controls in reset", {busy, done, sample_sw, start_ignored}, 0);
      check(dac_code == 0 && result == 0, "R1 codes in reset", int'(dac_code) + int'(result), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(busy == 0 && done == 0 && sample_sw == 0 && start_ignored == 0,
            "R1 idle after reset", {busy, done, sample_sw, start_ignored}, 0);

      // Boundary codes
      convert(0, 0, 0, 0);
      convert(4095, 0, 1, 0);
      convert(2047, 0, 2, 0);
      convert(2048, 0, 3, 0);
      convert(3, 1, 2, 0);
      convert(4, 1, 2, 0);
      convert(4095, 1, 13, 0);
      convert(1023, 1, 4, 0);
      // Mid-conversion disturbance
      convert(2481, 0, 4, 1);
      convert(1234, 1, 3, 1);
      convert(7, 0, 0, 1);

      // Sweep over the code range in both modes
      len = 0;
      for (int v = 0; v < 4096; v += 13) begin
         convert(v, 0, len, 0);
         convert(v, 1, len, 0);
         len = (len + 1) % 6;
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule